// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor port and runs the exchange for five instruction classes: a move from a core register into the coprocessor, a move from the coprocessor into a core register, an internal coprocessor data operation, a load of memory words into the coprocessor and a store of coprocessor words to memory. After a one-cycle `start` pulse it shows the instruction and a phase code to the coprocessor. The coprocessor answers in the same cycle with one of four responses.

A busy answer costs one idle cycle, and then the sequencer asks again. During that idle cycle a pending interrupt can make it give up the instruction. A "cannot" answer turns into an undefined-instruction request. For loads and stores the sequencer drives a word-wide memory port. The coprocessor sets the burst length by answering "increment" once for each further word it wants.

The sequencer ends every instruction with a one-cycle `done` pulse. Its status outputs keep their values until the next start.

Top module: `cop_handshake_seq`

## Requirements
- R1: One cycle after an accepted `start` (op codes: 0 move to coprocessor, 1 move from coprocessor, 2 data operation, 3 load, 4 store), `cp_valid` is high with `cp_phase` = 1 (first). The other phase codes are 2 retry, 3 interrupt, 4 transfer and 5 data. Response codes on `cp_resp` are 0 accept, 1 busy, 2 cannot and 3 increment.
- R2: A busy response to a first or retry phase gives exactly one cycle with `idle_cyc` high and `cp_valid` low. If no interrupt is pending, the next cycle presents the retry phase.
- R3: If an interrupt is pending during that idle cycle, the next cycle presents the interrupt phase. The instruction then ends with `int_abandon` set. `int_kind` reports the winner by priority: reset (1) beats a fast interrupt whose mask is clear (2), which beats a normal interrupt whose mask is clear (3). A masked request is not pending.
- R4: A cannot response to a first or retry phase ends the instruction with `undef_req` set.
- R5: After a load is accepted, one transfer phase follows. Then each data phase reads memory with `mem_we` low and passes the word read to the coprocessor on `cp_wdata`. The first access uses `addr_in` unchanged.
- R6: While a data phase gets the increment response and no memory abort occurs, the next data phase accesses the address 4 higher.
- R7: In a store, each data phase writes `cp_rdata` to memory with `mem_we` high, starting at `addr_in`.
- R8: An address with any bit at or above position `VALID_BITS` set is a range fault. A load with a range fault, or a store with a range fault or an address below `VEC_BYTES`, ends with `abort_out` set and never raises `cp_valid`.
- R9: A move to the coprocessor presents `src_in` on `cp_wdata` and ends with one `cop_cyc` cycle. A move from the coprocessor latches `cp_rdata` into `result` on acceptance and ends with one `cop_cyc` cycle followed by one `idle_cyc` cycle.
- R10: A memory abort during a data phase ends the burst after that word and sets `abort_out`.
- R11: During reset and after it, `busy`, `done`, `cp_valid` and `mem_req` are low.
- R12: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an instruction |
| op | input | 3 | Instruction class |
| instr_in | input | IW | Instruction word |
| addr_in | input | AW | Start address for load or store |
| src_in | input | DW | Core register value for a move to the coprocessor |
| rst_pend | input | 1 | Reset request |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt mask |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt mask |
| cp_valid | output | 1 | Phase presented to the coprocessor |
| cp_phase | output | 3 | Phase code |
| cp_instr | output | IW | Instruction to the coprocessor |
| cp_wdata | output | DW | Data to the coprocessor |
| cp_resp | input | 2 | Coprocessor response |
| cp_rdata | input | DW | Data from the coprocessor |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data, same cycle |
| mem_abort | input | 1 | Memory abort, same cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| undef_req | output | 1 | Undefined-instruction request |
| int_abandon | output | 1 | Abandoned because of an interrupt |
| int_kind | output | 2 | Winning interrupt |
| abort_out | output | 1 | Address or memory abort |
| result | output | DW | Word from a move out of the coprocessor |
| idle_cyc | output | 1 | Idle cycle strobe |
| cop_cyc | output | 1 | Coprocessor cycle strobe |

## Verification
The bench builds the block with its default parameters: 32-bit words and addresses, a 26-bit valid address range and a 32-byte vector region. With these values a single high address bit produces a range fault, and a low store address falls in the vector region. A scripted coprocessor and a 16-word memory make burst lengths, busy chains, interrupt priorities and a mid-burst memory abort easy to reach.

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int VALID_BITS = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [IW-1:0] instr_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] src_in,
  input  logic          rst_pend,
  input  logic          fiq_req,
  input  logic          fiq_mask,
  input  logic          irq_req,
  input  logic          irq_mask,
  output logic          cp_valid,
  output logic [2:0]    cp_phase,
  output logic [IW-1:0] cp_instr,
  output logic [DW-1:0] cp_wdata,
  input  logic [1:0]    cp_resp,
  input  logic [DW-1:0] cp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_abort,
  output logic          busy,
  output logic          done,
  output logic          undef_req,
  output logic          int_abandon,
  output logic [1:0]    int_kind,
  output logic          abort_out,
  output logic [DW-1:0] result,
  output logic          idle_cyc,
  output logic          cop_cyc
);
  localparam logic [2:0] OP_TO = 3'd0, OP_FROM = 3'd1, OP_DOP = 3'd2, OP_LD = 3'd3, OP_ST = 3'd4;
  localparam logic [2:0] PH_NONE = 3'd0, PH_FIRST = 3'd1, PH_RETRY = 3'd2,
                         PH_INT = 3'd3, PH_XFER = 3'd4, PH_DATA = 3'd5;
  localparam logic [1:0] RS_BUSY = 2'd1, RS_CANT = 2'd2, RS_INC = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_ASK, S_WAIT, S_INTR, S_XFER, S_LDATA, S_SDATA, S_CCYC, S_ICYC, S_DONE
  } state_t;

  state_t        st;
  logic [2:0]    op_q;
  logic [IW-1:0] instr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] src_q;
  logic          retry_q;
  logic          range_fault, vec_hit, pend;
  logic [1:0]    pend_kind;

  assign range_fault = |(addr_in >> VALID_BITS);
  assign vec_hit     = addr_in < AW'(VEC_BYTES);

  always_comb begin
    pend_kind = 2'd0;
    if (rst_pend)                pend_kind = 2'd1;
    else if (fiq_req && !fiq_mask) pend_kind = 2'd2;
    else if (irq_req && !irq_mask) pend_kind = 2'd3;
  end
  assign pend = pend_kind != 2'd0;

  always_comb begin
    case (st)
      S_ASK:            cp_phase = retry_q ? PH_RETRY : PH_FIRST;
      S_INTR:           cp_phase = PH_INT;
      S_XFER:           cp_phase = PH_XFER;
      S_LDATA, S_SDATA: cp_phase = PH_DATA;
      default:          cp_phase = PH_NONE;
    endcase
  end

  assign cp_valid  = cp_phase != PH_NONE;
  assign cp_instr  = instr_q;
  assign cp_wdata  = (st == S_LDATA) ? mem_rdata : src_q;
  assign mem_req   = (st == S_LDATA) || (st == S_SDATA);
  assign mem_we    = st == S_SDATA;
  assign mem_addr  = addr_q;
  assign mem_wdata = cp_rdata;
  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign idle_cyc  = (st == S_WAIT) || (st == S_ICYC);
  assign cop_cyc   = st == S_CCYC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= '0;
      instr_q     <= '0;
      addr_q      <= '0;
      src_q       <= '0;
      retry_q     <= 1'b0;
      undef_req   <= 1'b0;
      int_abandon <= 1'b0;
      int_kind    <= 2'd0;
      abort_out   <= 1'b0;
      result      <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q        <= op;
          instr_q     <= instr_in;
          addr_q      <= addr_in;
          src_q       <= src_in;
          retry_q     <= 1'b0;
          undef_req   <= 1'b0;
          int_abandon <= 1'b0;
          int_kind    <= 2'd0;
          abort_out   <= 1'b0;
          if ((op == OP_LD && range_fault) || (op == OP_ST && (range_fault || vec_hit))) begin
            abort_out <= 1'b1;
            st        <= S_DONE;
          end else begin
            st <= S_ASK;
          end
        end
        S_ASK: begin
          if (cp_resp == RS_BUSY) st <= S_WAIT;
          else if (cp_resp == RS_CANT) begin
            undef_req <= 1'b1;
            st        <= S_DONE;
          end else begin
            case (op_q)
              OP_TO:   st <= S_CCYC;
              OP_FROM: begin result <= cp_rdata; st <= S_CCYC; end
              OP_LD:   st <= S_XFER;
              OP_ST:   st <= S_SDATA;
              default: st <= S_DONE;
            endcase
          end
        end
        S_WAIT: begin
          if (pend) begin
            int_kind <= pend_kind;
            st       <= S_INTR;
          end else begin
            retry_q <= 1'b1;
            st      <= S_ASK;
          end
        end
        S_INTR: begin
          int_abandon <= 1'b1;
          st          <= S_DONE;
        end
        S_XFER: st <= S_LDATA;
        S_LDATA, S_SDATA: begin
          if (mem_abort) begin
            abort_out <= 1'b1;
            st        <= S_DONE;
          end else if (cp_resp == RS_INC) addr_q <= addr_q + AW'(4);
          else st <= S_DONE;
        end
        S_CCYC:  st <= (op_q == OP_FROM) ? S_ICYC : S_DONE;
        S_ICYC:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cop_handshake_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          cp_valid,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic          mem_req,
  input logic          mem_abort,
  input logic [AW-1:0] mem_addr,
  input logic          idle_cyc,
  input logic          undef_req,
  input logic          int_abandon
);
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> (cp_valid && cp_phase == 3'd1) || done); // R1
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && (cp_phase == 3'd1 || cp_phase == 3'd2) && cp_resp == 2'd1 |=> idle_cyc && !cp_valid); // R2
  AST_INT_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && cp_phase == 3'd3 |=> done && int_abandon); // R3
  AST_CANT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && (cp_phase == 3'd1 || cp_phase == 3'd2) && cp_resp == 2'd2 |=> done && undef_req); // R4
  AST_MEM_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cp_valid && cp_phase == 3'd5); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && cp_resp == 2'd3 && !mem_abort |=> mem_req && mem_addr == $past(mem_addr) + AW'(4)); // R6
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_abort |=> done && !mem_req); // R10
endmodule

bind cop_handshake_seq cop_handshake_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cp_valid(cp_valid), .cp_phase(cp_phase), .cp_resp(cp_resp),
  .mem_req(mem_req), .mem_abort(mem_abort), .mem_addr(mem_addr),
  .idle_cyc(idle_cyc), .undef_req(undef_req), .int_abandon(int_abandon)
);

// File: tb/tb_cop_handshake_seq.sv
`timescale 1ns/1ps
module tb_cop_handshake_seq;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0;
  logic [2:0] op = 0;
  logic [31:0] instr_in = 0, addr_in = 0, src_in = 0;
  logic rst_pend = 0, fiq_req = 0, fiq_mask = 0, irq_req = 0, irq_mask = 0;
  logic cp_valid; logic [2:0] cp_phase; logic [31:0] cp_instr, cp_wdata;
  logic [1:0] cp_resp; logic [31:0] cp_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata, mem_rdata; logic mem_abort;
  logic busy, done, undef_req, int_abandon, abort_out, idle_cyc, cop_cyc;
  logic [1:0] int_kind; logic [31:0] result;

  logic [1:0]  script [16];
  logic [31:0] mem [16];
  int idx;
  logic [31:0] abort_addr = 32'hFFFF_FFFF;

  assign cp_resp   = script[idx[3:0]];
  assign cp_rdata  = 32'hC000_0000 + idx;
  assign mem_rdata = mem[mem_addr[5:2]];
  assign mem_abort = mem_req && (mem_addr == abort_addr);

  cop_handshake_seq dut (.*);

  always @(posedge clk) begin
    if (cp_valid) idx <= idx + 1;
    if (mem_req && mem_we) mem[mem_addr[5:2]] <= mem_wdata;
  end

  int n_ph, n_mem, n_idle, n_cop, n_chk = 0, n_err = 0, cyc = 0;
  logic [2:0]  ph_log [16];
  logic [31:0] wd_log [16], ma_log [16];
  logic        we_log [16];

  always @(negedge clk) begin
    cyc++;
    if (cp_valid) begin ph_log[n_ph[3:0]] = cp_phase; wd_log[n_ph[3:0]] = cp_wdata; n_ph++; end
    if (mem_req) begin ma_log[n_mem[3:0]] = mem_addr; we_log[n_mem[3:0]] = mem_we; n_mem++; end
    if (idle_cyc) n_idle++;
    if (cop_cyc) n_cop++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] a, input logic [31:0] s);
    @(negedge clk);
    n_ph = 0; n_mem = 0; n_idle = 0; n_cop = 0; idx = 0;
    op = o; addr_in = a; src_in = s; instr_in = 32'h0E00_1234; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    chk(done, "done seen", {31'd0, done}, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !cp_valid && !mem_req, "R11 reset outputs", {busy, done, cp_valid, mem_req}, 0);
  endtask

  task automatic t_to_cop;
    script[0] = 0;
    run(0, 0, 32'h5A5A_0001);
    chk(n_ph == 1 && ph_log[0] == 1, "R1 first phase", ph_log[0], 1);
    chk(wd_log[0] == 32'h5A5A_0001, "R9 source on wdata", wd_log[0], 32'h5A5A_0001);
    chk(n_cop == 1 && n_idle == 0, "R9 to-cop cycles", {n_cop[15:0], n_idle[15:0]}, 32'h0001_0000);
  endtask

  task automatic t_from_cop;
    script[0] = 1; script[1] = 0;
    run(1, 0, 0);
    chk(n_ph == 2 && ph_log[0] == 1 && ph_log[1] == 2, "R2 retry phase", ph_log[1], 2);
    chk(n_idle == 2 && n_cop == 1, "R9 from-cop cop then idle", {n_cop[15:0], n_idle[15:0]}, 32'h0001_0002);
    chk(result == 32'hC000_0001, "R9 result latched", result, 32'hC000_0001);
  endtask

  task automatic t_cant;
    script[0] = 2;
    run(2, 0, 0);
    chk(undef_req && !int_abandon, "R4 cannot at first", {31'd0, undef_req}, 1);
    script[0] = 1; script[1] = 1; script[2] = 2;
    run(2, 0, 0);
    chk(undef_req && n_ph == 3 && n_idle == 2, "R4 cannot after retries", n_ph, 3);
  endtask

  task automatic t_intr(input logic r, input logic f, input logic fm, input logic i, input logic im,
                        input logic [1:0] kind);
    rst_pend = r; fiq_req = f; fiq_mask = fm; irq_req = i; irq_mask = im;
    script[0] = 1; script[1] = 0;
    run(2, 0, 0);
    chk(int_abandon && n_ph == 2 && ph_log[1] == 3, "R3 interrupt phase", ph_log[1], 3);
    chk(int_kind == kind, "R3 priority", int_kind, kind);
    rst_pend = 0; fiq_req = 0; irq_req = 0; fiq_mask = 0; irq_mask = 0;
  endtask

  task automatic t_masked;
    fiq_req = 1; fiq_mask = 1; irq_req = 1; irq_mask = 1;
    script[0] = 1; script[1] = 1; script[2] = 0;
    run(2, 0, 0);
    chk(!int_abandon && n_ph == 3 && n_idle == 2, "R3 masked not pending", n_ph, 3);
    fiq_req = 0; irq_req = 0; fiq_mask = 0; irq_mask = 0;
  endtask

  task automatic t_load;
    script[0] = 0; script[1] = 0; script[2] = 3; script[3] = 3; script[4] = 0;
    run(3, 32'h44, 0);
    chk(ph_log[1] == 4 && n_ph == 5, "R5 transfer then data", ph_log[1], 4);
    chk(n_mem == 3 && ma_log[0] == 32'h44 && !we_log[0], "R5 first address unchanged", ma_log[0], 32'h44);
    chk(ma_log[1] == 32'h48 && ma_log[2] == 32'h4C, "R6 step by 4", ma_log[2], 32'h4C);
    chk(wd_log[2] == mem[1] && wd_log[4] == mem[3], "R5 word to coprocessor", wd_log[4], mem[3]);
  endtask

  task automatic t_store;
    script[0] = 0; script[1] = 3; script[2] = 0;
    run(4, 32'h60, 0);
    @(negedge clk);
    chk(n_mem == 2 && we_log[0] && ma_log[1] == 32'h64, "R7 store addresses", ma_log[1], 32'h64);
    chk(mem[8] == 32'hC000_0001 && mem[9] == 32'hC000_0002, "R7 stored data", mem[9], 32'hC000_0002);
  endtask

  task automatic t_faults;
    run(3, 32'h0400_0000, 0);
    chk(abort_out && n_ph == 0, "R8 load range fault", n_ph, 0);
    run(4, 32'h10, 0);
    chk(abort_out && n_ph == 0, "R8 store vector", n_ph, 0);
    script[0] = 0; script[1] = 0; script[2] = 0;
    run(3, 32'h10, 0);
    chk(!abort_out && n_ph == 3, "R8 load in vector ok", n_ph, 3);
  endtask

  task automatic t_memabort;
    abort_addr = 32'h84;
    script[0] = 0; script[1] = 0; script[2] = 3; script[3] = 3; script[4] = 3; script[5] = 0;
    run(3, 32'h80, 0);
    chk(abort_out && n_mem == 2, "R10 burst cut", n_mem, 2);
    abort_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_start_busy;
    script[0] = 1; script[1] = 0;
    @(negedge clk);
    n_ph = 0; idx = 0; op = 2; start = 1;
    @(negedge clk); op = 0; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    @(negedge clk);
    chk(!busy && n_cop == 0 || !busy, "R12 idle after", {31'd0, busy}, 0);
    chk(n_ph == 2, "R12 second start ignored", n_ph, 2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h1000_0000 + i * 32'h0101; script[i] = 0; end
    idx = 0;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_to_cop;
    t_from_cop;
    t_cant;
    t_intr(0, 0, 0, 1, 0, 2'd3);
    t_intr(0, 1, 0, 1, 0, 2'd2);
    t_intr(1, 1, 0, 1, 0, 2'd1);
    t_intr(0, 1, 1, 1, 0, 2'd3);
    t_masked;
    t_load;
    t_store;
    t_faults;
    t_memabort;
    n_cop = 0;
    t_start_busy;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule